// File: doc/BRIEF.md
# NAND Address-Decoded Bus Bridge

This block sits on a processor memory window and turns ordinary loads and stores into cycles on an asynchronous NAND flash bus. It needs no command register for the flash itself. The type of each flash cycle comes from two low address bits of the store. One sets the command latch, the other sets the address latch, and when neither is set the cycle carries data. A configurable address mask moves the access from the primary chip enable to a secondary enable, which serves multichip packages. A 32-bit access is broken into back-to-back bus-width transfers, least significant lane first. A single-lane access drives one transfer, which is the usual way to send commands and addresses.

A small register space sits beside the flash window. It holds a control register with one NAND-mode enable per core chip select, and a status register that reports the shared wait line after a two-flop synchronizer. A read-only revision register completes the space. Each access is started by a one-cycle request pulse and ends with a one-cycle acknowledge. The acknowledge is held off until every transfer of a split access has finished its recovery time.

Top module: `nand_win_bridge`

## Requirements
- R1: A flash write to an address with bit 4 set is a command cycle. `nand_cle_o` is 1 and `nand_ale_o` is 0 while `nand_we_no` is low.
- R2: A flash write to an address with bit 3 set and bit 4 clear is an address cycle, with `nand_ale_o` set to 1 and `nand_cle_o` set to 0. When bits 4 and 3 are both set, only `nand_cle_o` is raised.
- R3: A flash write with bits 4 and 3 both clear is a data cycle. A flash read is always a data cycle, with CLE, ALE and `nand_dq_oe_o` all 0 while `nand_re_no` is low.
- R4: With `cpu_wide_i`=1 an access makes 32/NAND_DW transfers, carrying bits [k*NAND_DW +: NAND_DW] in transfer k. With `cpu_wide_i`=0 it makes one transfer of bits [NAND_DW-1:0]. Address bits 1:0 have no effect. A narrow read returns the lane zero-extended.
- R5: Each transfer drives its strobe (`nand_we_no` for writes, `nand_re_no` for reads) low for exactly STROBE_CYC clocks. The strobe is then high for exactly RECOV_CYC clocks before the next transfer. The two strobes are never low together.
- R6: When `cpu_addr_i & CHIPSEL_MASK` is nonzero, `nand_ce_sec_no` is low during the transfers and all primary enables stay high. Otherwise only `nand_ce_no[cpu_cs_i]` is low. Exactly one enable is low while a strobe is low.
- R7: A flash access raises `cpu_ack_o` for one cycle, beats*(STROBE_CYC+RECOV_CYC)+1 clocks after the request edge. Requests that arrive while the access is in flight are ignored.
- R8: Status register (cpu_addr_i[3:2]=1) bit 0 reads `nand_wait_i` as seen through two flops. A read issued one clock after the wait line changes still returns the old level.
- R9: Control register (cpu_addr_i[3:2]=0) bits CS_COUNT-1:0 are the NAND-mode enables and reset to 0. A flash access to a chip select whose bit is clear produces no strobe, is acknowledged one clock after the request, and reads as 0.
- R10: Revision register (cpu_addr_i[3:2]=2) reads {16'h0, REV_MAJOR, REV_MINOR}. Writes to it are ignored.
- R11: Out of reset all enables and strobes are high, while CLE, ALE, `nand_dq_oe_o` and `cpu_ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | One-cycle request pulse |
| cpu_reg_i | input | 1 | 1 = register space, 0 = flash window |
| cpu_we_i | input | 1 | 1 = write |
| cpu_wide_i | input | 1 | 1 = 32-bit access split into lanes |
| cpu_cs_i | input | CSW | Core chip select |
| cpu_addr_i | input | AW | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Read data, valid with ack |
| cpu_ack_o | output | 1 | One-cycle completion |
| nand_ce_no | output | CS_COUNT | Primary chip enables, active low |
| nand_ce_sec_no | output | 1 | Secondary chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | NAND_DW | Flash data out |
| nand_dq_oe_o | output | 1 | Flash data output enable |
| nand_dq_i | input | NAND_DW | Flash data in |
| nand_wait_i | input | 1 | Shared wire-AND ready/busy, 1 = ready |

## Verification
The hardest situation to reach from the ports is a second request that lands in the middle of a split access. The bench fires a wide write and pulses a command write five clocks later, while the first strobe sequence is still running. The scoreboard then checks that only the four lanes of the first access appear and that only one acknowledge is seen. The synchronizer depth is also hard to observe. To see it, the bench flips the wait line and reads status exactly one clock later, and expects the old level.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
  localparam int CLE_BIT = 4;
  localparam int ALE_BIT = 3;

  typedef enum logic [1:0] {CYC_DATA, CYC_ADDR, CYC_CMD} cyc_e;
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_RECOV, ST_DONE} seq_e;

  function automatic cyc_e decode_cyc(input logic we, input logic cle_bit, input logic ale_bit);
    if (!we)          return CYC_DATA;
    else if (cle_bit) return CYC_CMD;
    else if (ale_bit) return CYC_ADDR;
    else              return CYC_DATA;
  endfunction
endpackage

// File: rtl/nwb_decode.sv
module nwb_decode import nwb_pkg::*; #(
  parameter int AW = 16,
  parameter int CS_COUNT = 4,
  parameter logic [AW-1:0] CHIPSEL_MASK = 16'h4000,
  localparam int CSW = $clog2(CS_COUNT)
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [CSW-1:0]    cs_i,
  output cyc_e              cyc_o,
  output logic [CS_COUNT:0] sel_o
);
  logic sec;
  assign sec   = |(addr_i & CHIPSEL_MASK);
  assign cyc_o = decode_cyc(we_i, addr_i[CLE_BIT], addr_i[ALE_BIT]);
  // top bit = secondary enable, replaces the primary one
  assign sel_o = sec ? {1'b1, {CS_COUNT{1'b0}}} : ((CS_COUNT+1)'(1) << cs_i);
endmodule

// File: rtl/nwb_sync.sv
module nwb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end
  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nwb_seq.sv
module nwb_seq import nwb_pkg::*; #(
  parameter int CS_COUNT = 4,
  parameter int NAND_DW = 8,
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC = 2,
  localparam int BEATS = 32 / NAND_DW,
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int MAXC = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               we_i,
  input  logic               wide_i,
  input  cyc_e               cyc_i,
  input  logic [CS_COUNT:0]  sel_i,
  input  logic [31:0]        wdata_i,
  input  logic [NAND_DW-1:0] dq_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [31:0]        rdata_o,
  output logic               we_no,
  output logic               re_no,
  output logic               cle_o,
  output logic               ale_o,
  output logic [CS_COUNT:0]  ce_o,
  output logic [NAND_DW-1:0] dq_o,
  output logic               dq_oe_o
);
  seq_e              st_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     beats_q;
  logic              we_q, wide_q;
  cyc_e              cyc_q;
  logic [CS_COUNT:0] sel_q;
  logic [31:0]       wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      beats_q <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      cyc_q   <= CYC_DATA;
      sel_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_STROBE;
          cnt_q   <= CW'(STROBE_CYC - 1);
          beats_q <= wide_i ? BW'(BEATS - 1) : '0;
          we_q    <= we_i;
          wide_q  <= wide_i;
          cyc_q   <= cyc_i;
          sel_q   <= sel_i;
          wdata_q <= wdata_i;
        end
        ST_STROBE: if (cnt_q == '0) begin
          if (!we_q) rdata_q <= {dq_i, rdata_q[31:NAND_DW]};
          st_q  <= ST_RECOV;
          cnt_q <= CW'(RECOV_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_RECOV: if (cnt_q == '0) begin
          if (beats_q == '0) st_q <= ST_DONE;
          else begin
            beats_q <= beats_q - 1'b1;
            wdata_q <= wdata_q >> NAND_DW;
            st_q    <= ST_STROBE;
            cnt_q   <= CW'(STROBE_CYC - 1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic active;
  assign active  = (st_q == ST_STROBE) || (st_q == ST_RECOV);
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign we_no   = !((st_q == ST_STROBE) && we_q);
  assign re_no   = !((st_q == ST_STROBE) && !we_q);
  assign cle_o   = active && we_q && (cyc_q == CYC_CMD);
  assign ale_o   = active && we_q && (cyc_q == CYC_ADDR);
  assign ce_o    = active ? sel_q : '0;
  assign dq_o    = wdata_q[NAND_DW-1:0];
  assign dq_oe_o = active && we_q;
  assign rdata_o = wide_q ? rdata_q : 32'(rdata_q[31 -: NAND_DW]);
endmodule

// File: rtl/nwb_regs.sv
module nwb_regs #(
  parameter int CS_COUNT = 4,
  parameter logic [7:0] REV_MAJOR = 8'h02,
  parameter logic [7:0] REV_MINOR = 8'h05
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          idx_i,
  input  logic [CS_COUNT-1:0] wdata_i,
  input  logic                ready_i,
  output logic [CS_COUNT-1:0] mode_o,
  output logic                ack_o,
  output logic [31:0]         rdata_o
);
  logic [CS_COUNT-1:0] mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= req_i;
      if (req_i) begin
        if (we_i && idx_i == 2'd0) mode_q <= wdata_i;
        unique case (idx_i)
          2'd0:    rdata_o <= 32'(mode_q);
          2'd1:    rdata_o <= {31'b0, ready_i};
          2'd2:    rdata_o <= {16'b0, REV_MAJOR, REV_MINOR};
          default: rdata_o <= '0;
        endcase
      end
    end
  end
  assign mode_o = mode_q;
endmodule

// File: rtl/nand_win_bridge.sv
module nand_win_bridge import nwb_pkg::*; #(
  parameter int AW = 16,
  parameter int CS_COUNT = 4,
  parameter int NAND_DW = 8,
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC = 2,
  parameter logic [AW-1:0] CHIPSEL_MASK = 16'h4000,
  parameter logic [7:0] REV_MAJOR = 8'h02,
  parameter logic [7:0] REV_MINOR = 8'h05,
  localparam int CSW = $clog2(CS_COUNT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_reg_i,
  input  logic                cpu_we_i,
  input  logic                cpu_wide_i,
  input  logic [CSW-1:0]      cpu_cs_i,
  input  logic [AW-1:0]       cpu_addr_i,
  input  logic [31:0]         cpu_wdata_i,
  output logic [31:0]         cpu_rdata_o,
  output logic                cpu_ack_o,
  output logic [CS_COUNT-1:0] nand_ce_no,
  output logic                nand_ce_sec_no,
  output logic                nand_cle_o,
  output logic                nand_ale_o,
  output logic                nand_we_no,
  output logic                nand_re_no,
  output logic [NAND_DW-1:0]  nand_dq_o,
  output logic                nand_dq_oe_o,
  input  logic [NAND_DW-1:0]  nand_dq_i,
  input  logic                nand_wait_i
);
  logic                busy, seq_done, reg_ack, skip_ack_q, ready_s;
  logic                accept, flash_start;
  logic [CS_COUNT-1:0] mode;
  logic [31:0]         seq_rdata, reg_rdata;
  cyc_e                cyc;
  logic [CS_COUNT:0]   sel, ce;

  assign accept      = cpu_req_i && !busy;
  assign flash_start = accept && !cpu_reg_i && mode[cpu_cs_i];

  nwb_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(nand_wait_i), .q_o(ready_s)
  );

  nwb_regs #(.CS_COUNT(CS_COUNT), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
    .clk_i, .rst_ni,
    .req_i(accept && cpu_reg_i), .we_i(cpu_we_i), .idx_i(cpu_addr_i[3:2]),
    .wdata_i(cpu_wdata_i[CS_COUNT-1:0]), .ready_i(ready_s),
    .mode_o(mode), .ack_o(reg_ack), .rdata_o(reg_rdata)
  );

  nwb_decode #(.AW(AW), .CS_COUNT(CS_COUNT), .CHIPSEL_MASK(CHIPSEL_MASK)) u_dec (
    .addr_i(cpu_addr_i), .we_i(cpu_we_i), .cs_i(cpu_cs_i), .cyc_o(cyc), .sel_o(sel)
  );

  nwb_seq #(.CS_COUNT(CS_COUNT), .NAND_DW(NAND_DW), .STROBE_CYC(STROBE_CYC),
            .RECOV_CYC(RECOV_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i(flash_start), .we_i(cpu_we_i), .wide_i(cpu_wide_i),
    .cyc_i(cyc), .sel_i(sel), .wdata_i(cpu_wdata_i), .dq_i(nand_dq_i),
    .busy_o(busy), .done_o(seq_done), .rdata_o(seq_rdata),
    .we_no(nand_we_no), .re_no(nand_re_no), .cle_o(nand_cle_o), .ale_o(nand_ale_o),
    .ce_o(ce), .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe_o)
  );

  // flash access to a chip select not in NAND mode: acked, no cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) skip_ack_q <= 1'b0;
    else         skip_ack_q <= accept && !cpu_reg_i && !mode[cpu_cs_i];
  end

  assign nand_ce_no     = ~ce[CS_COUNT-1:0];
  assign nand_ce_sec_no = ~ce[CS_COUNT];
  assign cpu_ack_o      = seq_done || reg_ack || skip_ack_q;
  assign cpu_rdata_o    = seq_done ? seq_rdata : (reg_ack ? reg_rdata : '0);
endmodule

// File: rtl/nwb_checker.sv
module nwb_checker #(
  parameter int CS_COUNT = 4,
  parameter int STROBE_CYC = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cpu_ack_o,
  input logic [CS_COUNT-1:0] nand_ce_no,
  input logic                nand_ce_sec_no,
  input logic                nand_cle_o,
  input logic                nand_ale_o,
  input logic                nand_we_no,
  input logic                nand_re_no,
  input logic                nand_dq_oe_o
);
  logic strb_hi;
  int   lowc;
  assign strb_hi = nand_we_no && nand_re_no;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lowc <= 0;
    else if (!strb_hi) lowc <= lowc + 1;
    else               lowc <= 0;
  end

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  assert_strobe_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_hi) |-> (lowc == STROBE_CYC));
  assert_cle_over_ale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  assert_read_data_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> (!nand_cle_o && !nand_ale_o && !nand_dq_oe_o));
  assert_one_ce_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_hi |-> ($countones({~nand_ce_sec_no, ~nand_ce_no}) == 1));
  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);
endmodule

bind nand_win_bridge nwb_checker #(.CS_COUNT(CS_COUNT), .STROBE_CYC(STROBE_CYC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_ack_o(cpu_ack_o), .nand_ce_no(nand_ce_no),
  .nand_ce_sec_no(nand_ce_sec_no), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
  .nand_we_no(nand_we_no), .nand_re_no(nand_re_no), .nand_dq_oe_o(nand_dq_oe_o)
);

// File: tb/nand_win_bridge_tb_top.sv
`timescale 1ns/1ps
module nand_win_bridge_tb_top;
  localparam int S = 3, R = 2, BEATS = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, rg = 0, we = 0, wide = 0, wait_in = 1'b1;
  logic [1:0]  cs = '0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ack;
  logic [3:0]  ce_n;
  logic        sec_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]  dq_o, rd_byte = 8'h30;

  always #2.5 clk = ~clk;

  nand_win_bridge #(.STROBE_CYC(S), .RECOV_CYC(R)) dut_i (
    .clk_i(clk), .rst_ni, .cpu_req_i(req), .cpu_reg_i(rg), .cpu_we_i(we),
    .cpu_wide_i(wide), .cpu_cs_i(cs), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .cpu_ack_o(ack), .nand_ce_no(ce_n), .nand_ce_sec_no(sec_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe), .nand_dq_i(rd_byte), .nand_wait_i(wait_in)
  );

  int checks = 0, failures = 0, ack_cnt = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  typedef struct {bit wr; bit cle; bit ale; logic [4:0] ce; logic [7:0] d; bit first;} ev_t;
  ev_t q[$];

  // monitor: one scoreboard entry per strobe
  initial begin
    bit prev_low = 0, prev_rd = 0;
    int low_cnt = 0, gap_cnt = 0;
    ev_t e;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        bit low;
        low = !we_n || !re_n;
        if (ack) ack_cnt++;
        if (low && !prev_low) begin
          low_cnt = 1;
          prev_rd = !re_n;
          if (q.size() == 0) chk(0, "R9", "unexpected strobe", {we_n, re_n}, 0);
          else begin
            e = q.pop_front();
            chk(e.wr == !we_n, "R3", "strobe kind", !we_n, e.wr);
            chk(cle == e.cle, "R1", "cle", cle, e.cle);
            chk(ale == e.ale, "R2", "ale", ale, e.ale);
            chk({~sec_n, ~ce_n} == e.ce, "R6", "chip enables", {~sec_n, ~ce_n}, e.ce);
            if (e.wr) chk(dq_o == e.d && dq_oe, "R4", "lane data", dq_o, e.d);
            else      chk(!dq_oe, "R3", "oe on read", dq_oe, 0);
            if (!e.first) chk(gap_cnt == R, "R5", "recovery clocks", gap_cnt, R);
          end
        end else if (low) low_cnt++;
        else if (prev_low) begin
          chk(low_cnt == S, "R5", "strobe clocks", low_cnt, S);
          gap_cnt = 1;
          if (prev_rd) rd_byte = rd_byte + 8'd1;
        end else gap_cnt++;
        prev_low = low;
      end
    end
  end

  // driver: pushes expectations, issues request, checks ack timing
  task automatic access(input bit r, input bit w, input bit wd, input bit en,
                        input logic [1:0] c, input logic [15:0] a, input logic [31:0] d,
                        input string rq, output logic [31:0] rd);
    int nb, k, expk;
    nb = wd ? BEATS : 1;
    expk = (r || !en) ? 1 : nb * (S + R) + 1;
    if (!r && en)
      for (int b = 0; b < nb; b++) begin
        ev_t e;
        e.wr = w; e.cle = w && a[4]; e.ale = w && !a[4] && a[3];
        e.ce = a[14] ? 5'b10000 : (5'b00001 << c);
        e.d = d[8*b +: 8]; e.first = (b == 0);
        q.push_back(e);
      end
    rg = r; we = w; wide = wd; cs = c; addr = a; wdata = d; req = 1;
    @(negedge clk); req = 0;
    k = 1;
    while (!ack && k < 200) begin @(negedge clk); k++; end
    rd = rdata;
    chk(k == expk, rq, "ack latency", k, expk);
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    int a0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(we_n && re_n && sec_n && ce_n == 4'hF, "R11", "strobes/enables idle", {we_n, re_n, sec_n, ce_n}, 7'h7F);
    chk(!cle && !ale && !dq_oe && !ack, "R11", "latches/oe/ack idle", {cle, ale, dq_oe, ack}, 0);
    rst_ni = 1;
    @(negedge clk);
    access(1, 0, 0, 1, 0, 16'h0, 0, "R9", r);
    chk(r == 0, "R9", "ctrl reset value", r, 0);
    // R10 revision, write ignored
    access(1, 0, 0, 1, 0, 16'h8, 0, "R10", r);
    chk(r == 32'h0000_0205, "R10", "revision", r, 32'h205);
    access(1, 1, 0, 1, 0, 16'h8, 32'hFFFF_FFFF, "R10", r);
    access(1, 0, 0, 1, 0, 16'h8, 0, "R10", r);
    chk(r == 32'h0000_0205, "R10", "revision after write", r, 32'h205);
    // R9 disabled chip select: no strobe, fast ack
    access(0, 1, 1, 0, 0, 16'h0, 32'h1234_5678, "R9", r);
    access(1, 1, 0, 1, 0, 16'h0, 32'h3, "R9", r);
    access(1, 0, 0, 1, 0, 16'h0, 0, "R9", r);
    chk(r == 32'h3, "R9", "ctrl readback", r, 3);
    // R1 command, R2 address and precedence
    access(0, 1, 0, 1, 0, 16'h0010, 32'h70, "R1", r);
    access(0, 1, 0, 1, 0, 16'h0008, 32'h12, "R2", r);
    access(0, 1, 0, 1, 0, 16'h0018, 32'h55, "R2", r);
    // R4 wide data write, bits 1:0 ignored; R5 timing; R7 latency
    access(0, 1, 1, 1, 1, 16'h0003, 32'hDDCC_BBAA, "R4", r);
    // R6 secondary enable
    access(0, 1, 1, 1, 0, 16'h4000, 32'h0403_0201, "R6", r);
    // R3 read with bit 4 set stays a data cycle; R4 assembly
    b = rd_byte;
    access(0, 0, 1, 1, 1, 16'h0010, 0, "R3", r);
    chk(r == {b + 8'd3, b + 8'd2, b + 8'd1, b}, "R4", "wide read data", r, {b + 8'd3, b + 8'd2, b + 8'd1, b});
    b = rd_byte;
    access(0, 0, 0, 1, 0, 16'h0001, 0, "R4", r);
    chk(r == {24'h0, b}, "R4", "narrow read data", r, {24'h0, b});
    // R9 read on disabled chip select returns 0
    access(0, 0, 1, 0, 3, 16'h0, 0, "R9", r);
    chk(r == 0, "R9", "disabled read data", r, 0);
    // R7 request during split access is ignored
    a0 = ack_cnt;
    for (int i = 0; i < BEATS; i++) begin
      ev_t e;
      e.wr = 1; e.cle = 0; e.ale = 0; e.ce = 5'b00001; e.d = 8'h90 + 8'(i); e.first = (i == 0);
      q.push_back(e);
    end
    rg = 0; we = 1; wide = 1; cs = 0; addr = 16'h0; wdata = 32'h9392_9190; req = 1;
    @(negedge clk); req = 0;
    repeat (5) @(negedge clk);
    addr = 16'h0010; wide = 0; wdata = 32'hFF; req = 1;
    @(negedge clk); req = 0;
    repeat (40) @(negedge clk);
    chk(ack_cnt - a0 == 1, "R7", "acks for overlapped requests", ack_cnt - a0, 1);
    chk(q.size() == 0, "R7", "pending strobes", q.size(), 0);
    // R8 two-flop synchronizer
    wait_in = 0;
    @(negedge clk);
    access(1, 0, 0, 1, 0, 16'h4, 0, "R8", r);
    chk(r == 32'h1, "R8", "status one clock after change", r, 1);
    access(1, 0, 0, 1, 0, 16'h4, 0, "R8", r);
    chk(r == 32'h0, "R8", "status busy", r, 0);
    wait_in = 1;
    repeat (3) @(negedge clk);
    access(1, 0, 0, 1, 0, 16'h4, 0, "R8", r);
    chk(r == 32'h1, "R8", "status ready", r, 1);
    chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule